// File: doc/BRIEF.md
# Software-Reloaded Fully Associative TLB

This block translates 32-bit effective addresses into physical addresses through a table of fully associative entries. Every entry is compared at once. Each entry has its own page size, a 4-bit address-space tag and a 3-bit protection group. A lookup returns, one cycle after the request, these results:

- a hit flag
- the physical address
- a cache-inhibit attribute
- a write-through attribute
- an access-violation flag
- a multi-hit flag

No hardware walks the page tables. A missed lookup raises a one-cycle miss pulse and records the faulting address. A software miss handler then builds a new entry in two staging registers and commits it to a slot index of its choice. The handler can also use three scratch registers for its own working state. The same register port holds the per-group access rights and a command that invalidates every entry.

Top module: `sw_tlb`

## Requirements
- R1: A lookup request (`lk_valid`) produces `rsp_valid` on the next cycle. An entry hits when it is valid, its space tag equals `lk_space`, and its page number matches the effective address above the page offset. A 4 KB hit returns the entry's real page number in bits 31:12 and the effective address bits 11:0 unchanged.
- R2: The size code in staging-data bits 10:8 selects the page size: 0 = 4 KB, 1 = 16 KB, 2 = 256 KB, 3 = 512 KB, 4 = 8 MB, and codes 5 to 7 act as 4 KB. The offset bits of that size (12, 14, 18, 19 or 23 bits) bypass the tag compare and pass from the effective address into the physical address.
- R3: An entry whose space tag differs from the lookup's space tag never hits. Two entries with the same page number but different tags translate independently.
- R4: The rights register (address 4) holds 2 bits per group g. Bit 2g allows reads and bit 2g+1 allows writes. `rsp_viol` is 1 exactly when a lookup hits and the access kind is not allowed for the entry's group. It is 0 on a miss. The rights register resets to 0xFFFF.
- R5: On a hit, `rsp_inhibit` and `rsp_wthru` equal the entry's bits 1 and 0 of its staging-data word. On a miss they are 0.
- R6: A missed lookup gives `rsp_miss` = 1 for exactly that response cycle, with `rsp_hit` = 0. The effective address of that lookup becomes readable at address 5. A hit does not change that value.
- R7: Register layout: address 0 holds the staging tag (bits 31:12 page number, bit 11 valid, bits 3:0 space tag). Address 1 holds the staging data (bits 31:12 real page number, bits 10:8 size, bits 6:4 group, bit 1 inhibit, bit 0 write-through). A write to address 2 copies both staging registers into the slot given by bits 4:0 and replaces that slot's old contents.
- R8: A write of any value to address 3 clears the valid bit of every entry in one cycle. Every later lookup then misses.
- R9: When several entries hit, the lowest-indexed one supplies the result and `rsp_multi` is 1. With a single hit, `rsp_multi` is 0.
- R10: Addresses 6, 7 and 8 are scratch registers that read back the last value written. Writes to address 5 are ignored.
- R11: After reset there are no responses and no valid entries, the scratch registers read 0, and the rights register reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_space | input | 4 | Current address-space tag |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | One-cycle miss pulse |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | 32 | Physical address (0 on miss) |
| rsp_inhibit | output | 1 | Cache-inhibit attribute of the hit page |
| rsp_wthru | output | 1 | Write-through attribute of the hit page |
| rsp_viol | output | 1 | Access not allowed by the group's rights |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |

## Verification
The assertions check several rules on every cycle:

- a response only follows a request
- a miss and a hit never coincide
- a violation or multi-hit flag never appears without a hit
- the priority grant is at most one-hot
- an invalidate leaves no valid slot
- a commit lands the staged entry in the chosen slot
- the fault address changes only on a miss

Translation values need the bench's scenarios: the offset split at each page size, the space-tag separation, the rights decoding per group, the lowest-index choice among duplicates, and overwriting a slot. The same holds for scratch and fault-register behaviour seen through the register port.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Address geometry shared by all TLB modules.
    localparam int EA_W       = 32;
    localparam int MIN_SHIFT  = 12;
    localparam int VPN_W      = EA_W - MIN_SHIFT;
    localparam int SPACE_W    = 4;
    localparam int GRP_W      = 3;
    localparam int NUM_GRP    = 1 << GRP_W;
    localparam int SZ_W       = 3;
    localparam int RIGHTS_W   = 2 * NUM_GRP;
    localparam int RADDR_W    = 4;

    // Register port addresses.
    localparam logic [RADDR_W-1:0] RA_STAGE_TAG  = 4'd0;
    localparam logic [RADDR_W-1:0] RA_STAGE_DATA = 4'd1;
    localparam logic [RADDR_W-1:0] RA_COMMIT     = 4'd2;
    localparam logic [RADDR_W-1:0] RA_INVAL      = 4'd3;
    localparam logic [RADDR_W-1:0] RA_RIGHTS     = 4'd4;
    localparam logic [RADDR_W-1:0] RA_FAULT      = 4'd5;
    localparam logic [RADDR_W-1:0] RA_SCRATCH0   = 4'd6;

    // One translation slot.
    typedef struct packed {
        logic               valid;
        logic [VPN_W-1:0]   epn;
        logic [VPN_W-1:0]   rpn;
        logic [SPACE_W-1:0] space;
        logic [SZ_W-1:0]    size;
        logic [GRP_W-1:0]   grp;
        logic               inhibit;
        logic               wthru;
    } tlb_entry_t;

    // Number of page-number bits (above 4 KB) that fall inside the page offset.
    function automatic int unsigned extra_offset_bits(input logic [SZ_W-1:0] sz);
        case (sz)
            3'd1:    return 2;
            3'd2:    return 6;
            3'd3:    return 7;
            3'd4:    return 11;
            default: return 0;
        endcase
    endfunction

    // Page-number bits taking part in the tag compare (1 = compared).
    function automatic logic [VPN_W-1:0] tag_mask(input logic [SZ_W-1:0] sz);
        logic [VPN_W-1:0] m;
        m = '1;
        m = m << extra_offset_bits(sz);
        return m;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
// Storage for all translation slots.
// Does: holds NUM_ENTRIES entries, writes one slot per commit and clears
// every valid bit on a global invalidate (invalidate has priority).
// Assumes: wr_idx is below NUM_ENTRIES; reset is synchronous, active low.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  tlb_entry_t                    wr_entry,
    input  logic                          inval_all,
    output tlb_entry_t [NUM_ENTRIES-1:0]  entries_o
);

    tlb_entry_t ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valid_vec;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        // Per-slot update: reset, invalidate, or commit from the register port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (inval_all) begin
                ent_q[i].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_entry;
            end
        end
        assign entries_o[i] = ent_q[i];
        assign valid_vec[i] = ent_q[i].valid;
    end

    AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (valid_vec == '0)); // R8

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inval_all) |=> (ent_q[$past(wr_idx)] == $past(wr_entry))); // R7

endmodule

// File: rtl/tlb_match.sv
// Parallel tag comparators.
// Does: for every slot, flags a match when the slot is valid, the space tag
// agrees, and the page numbers agree on the bits the slot's size compares.
// Assumes: purely combinational; the caller registers the results.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [VPN_W-1:0]             ea_vpn,
    input  logic [SPACE_W-1:0]           space,
    output logic [NUM_ENTRIES-1:0]       match_vec
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        logic [VPN_W-1:0] diff;
        // Bits where the slot's page number and the address differ.
        assign diff = (entries[i].epn ^ ea_vpn) & tag_mask(entries[i].size);
        assign match_vec[i] = entries[i].valid
                            && (entries[i].space == space)
                            && (diff == '0);
    end

endmodule

// File: rtl/tlb_prio_sel.sv
// Match resolver.
// Does: picks the lowest-indexed matching slot, returns it with a one-hot
// grant, and reports whether more than one slot matched.
// Assumes: purely combinational.
module tlb_prio_sel
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [NUM_ENTRIES-1:0]       match_vec,
    output logic [NUM_ENTRIES-1:0]       grant,
    output logic                         any_hit,
    output logic                         multi_hit,
    output tlb_entry_t                   sel_entry
);

    // Lowest-index-first scan over the match vector.
    always_comb begin
        grant     = '0;
        any_hit   = 1'b0;
        sel_entry = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match_vec[i] && !any_hit) begin
                any_hit   = 1'b1;
                grant[i]  = 1'b1;
                sel_entry = entries[i];
            end
        end
    end

    // More than one slot matched.
    assign multi_hit = ($countones(match_vec) > 1);

endmodule

// File: rtl/tlb_sw_regs.sv
// Software register file for the refill routine.
// Does: staging tag/data registers, commit and invalidate commands, the group
// rights register, the fault-address register and the scratch registers.
// Assumes: one register access per cycle; reads are combinational on reg_addr.
module tlb_sw_regs
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_SCRATCH = 3,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [EA_W-1:0]      reg_wdata,
    output logic [EA_W-1:0]      reg_rdata,
    input  logic                 miss_evt,
    input  logic [EA_W-1:0]      miss_ea,
    output logic                 commit_en,
    output logic [IDX_W-1:0]     commit_idx,
    output tlb_entry_t           stage_entry,
    output logic                 inval_en,
    output logic [RIGHTS_W-1:0]  rights
);

    logic [VPN_W-1:0]   st_epn;
    logic               st_valid;
    logic [SPACE_W-1:0] st_space;
    logic [VPN_W-1:0]   st_rpn;
    logic [SZ_W-1:0]    st_size;
    logic [GRP_W-1:0]   st_grp;
    logic               st_inh;
    logic               st_wt;
    logic [EA_W-1:0]    fault_q;
    logic [EA_W-1:0]    scratch_q [NUM_SCRATCH];

    // Staging tag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_epn   <= '0;
            st_valid <= 1'b0;
            st_space <= '0;
        end else if (reg_we && reg_addr == RA_STAGE_TAG) begin
            st_epn   <= reg_wdata[EA_W-1:MIN_SHIFT];
            st_valid <= reg_wdata[11];
            st_space <= reg_wdata[SPACE_W-1:0];
        end
    end

    // Staging data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_rpn  <= '0;
            st_size <= '0;
            st_grp  <= '0;
            st_inh  <= 1'b0;
            st_wt   <= 1'b0;
        end else if (reg_we && reg_addr == RA_STAGE_DATA) begin
            st_rpn  <= reg_wdata[EA_W-1:MIN_SHIFT];
            st_size <= reg_wdata[10:8];
            st_grp  <= reg_wdata[6:4];
            st_inh  <= reg_wdata[1];
            st_wt   <= reg_wdata[0];
        end
    end

    // Group rights register, all accesses allowed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rights <= '1;
        end else if (reg_we && reg_addr == RA_RIGHTS) begin
            rights <= reg_wdata[RIGHTS_W-1:0];
        end
    end

    // Fault address: loaded by hardware on a miss only, never by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
        end else if (miss_evt) begin
            fault_q <= miss_ea;
        end
    end

    for (genvar s = 0; s < NUM_SCRATCH; s++) begin : g_scr
        // Scratch register s for the miss handler.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scratch_q[s] <= '0;
            end else if (reg_we && reg_addr == RA_SCRATCH0 + RADDR_W'(s)) begin
                scratch_q[s] <= reg_wdata;
            end
        end
    end

    assign commit_en  = reg_we && (reg_addr == RA_COMMIT);
    assign commit_idx = reg_wdata[IDX_W-1:0];
    assign inval_en   = reg_we && (reg_addr == RA_INVAL);

    always_comb begin
        stage_entry         = '0;
        stage_entry.valid   = st_valid;
        stage_entry.epn     = st_epn;
        stage_entry.rpn     = st_rpn;
        stage_entry.space   = st_space;
        stage_entry.size    = st_size;
        stage_entry.grp     = st_grp;
        stage_entry.inhibit = st_inh;
        stage_entry.wthru   = st_wt;
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_STAGE_TAG:  reg_rdata = {st_epn, st_valid, 7'd0, st_space};
            RA_STAGE_DATA: reg_rdata = {st_rpn, 1'b0, st_size, 1'b0, st_grp,
                                        2'b00, st_inh, st_wt};
            RA_RIGHTS:     reg_rdata = EA_W'(rights);
            RA_FAULT:      reg_rdata = fault_q;
            default: begin
                for (int s = 0; s < NUM_SCRATCH; s++) begin
                    if (reg_addr == RA_SCRATCH0 + RADDR_W'(s)) reg_rdata = scratch_q[s];
                end
            end
        endcase
    end

    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        miss_evt |=> (fault_q == $past(miss_ea))); // R6

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_evt |=> $stable(fault_q)); // R10

endmodule

// File: rtl/sw_tlb.sv
// Software-reloaded fully associative TLB, top level.
// Does: compares a lookup against all slots in parallel, resolves the winner,
// applies page size, rights and attributes, and registers the response one
// cycle after the request. Misses pulse rsp_miss and record the address.
// Assumes: synchronous active-low reset; register writes and lookups may share
// a cycle, in which case the lookup sees the table before the write.
module sw_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_SCRATCH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [EA_W-1:0]     lk_ea,
    input  logic [SPACE_W-1:0]  lk_space,
    input  logic                lk_write,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic                rsp_multi,
    output logic [EA_W-1:0]     rsp_pa,
    output logic                rsp_inhibit,
    output logic                rsp_wthru,
    output logic                rsp_viol,
    input  logic                reg_we,
    input  logic [RADDR_W-1:0]  reg_addr,
    input  logic [EA_W-1:0]     reg_wdata,
    output logic [EA_W-1:0]     reg_rdata
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);

    tlb_entry_t [NUM_ENTRIES-1:0] entries;
    logic [NUM_ENTRIES-1:0]       match_vec;
    logic [NUM_ENTRIES-1:0]       grant;
    logic                         any_hit;
    logic                         multi_hit;
    tlb_entry_t                   sel;
    logic                         commit_en;
    logic [IDX_W-1:0]             commit_idx;
    tlb_entry_t                   stage_entry;
    logic                         inval_en;
    logic [RIGHTS_W-1:0]          rights;
    logic [VPN_W-1:0]             keep_mask;
    logic [EA_W-1:0]              pa_comb;
    logic                         allowed;
    logic                         miss_evt;

    tlb_entry_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit_en),
        .wr_idx    (commit_idx),
        .wr_entry  (stage_entry),
        .inval_all (inval_en),
        .entries_o (entries)
    );

    tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .entries   (entries),
        .ea_vpn    (lk_ea[EA_W-1:MIN_SHIFT]),
        .space     (lk_space),
        .match_vec (match_vec)
    );

    tlb_prio_sel #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
        .entries   (entries),
        .match_vec (match_vec),
        .grant     (grant),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .sel_entry (sel)
    );

    tlb_sw_regs #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_SCRATCH(NUM_SCRATCH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .miss_evt    (miss_evt),
        .miss_ea     (lk_ea),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .stage_entry (stage_entry),
        .inval_en    (inval_en),
        .rights      (rights)
    );

    assign miss_evt = lk_valid && !any_hit;

    // Physical address: real page bits above the offset, address bits below.
    always_comb begin
        keep_mask = tag_mask(sel.size);
        pa_comb   = {(sel.rpn & keep_mask) | (lk_ea[EA_W-1:MIN_SHIFT] & ~keep_mask),
                     lk_ea[MIN_SHIFT-1:0]};
        allowed   = rights[{sel.grp, lk_write}];
    end

    // Response register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_multi   <= 1'b0;
            rsp_pa      <= '0;
            rsp_inhibit <= 1'b0;
            rsp_wthru   <= 1'b0;
            rsp_viol    <= 1'b0;
        end else begin
            rsp_valid   <= lk_valid;
            rsp_hit     <= lk_valid && any_hit;
            rsp_miss    <= miss_evt;
            rsp_multi   <= lk_valid && multi_hit;
            rsp_pa      <= (lk_valid && any_hit) ? pa_comb : '0;
            rsp_inhibit <= lk_valid && any_hit && sel.inhibit;
            rsp_wthru   <= lk_valid && any_hit && sel.wthru;
            rsp_viol    <= lk_valid && any_hit && !allowed;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid)); // R1

    AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (!rsp_hit && rsp_valid)); // R6

    AST_VIOL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> rsp_hit); // R4

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> rsp_hit); // R9

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R9

endmodule

// File: tb/tb_sw_tlb.sv
module tb_sw_tlb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write;
    logic [31:0] lk_ea;
    logic [3:0]  lk_space;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi;
    logic [31:0] rsp_pa;
    logic        rsp_inhibit, rsp_wthru, rsp_viol;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_space(lk_space), .lk_write(lk_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_multi(rsp_multi), .rsp_pa(rsp_pa), .rsp_inhibit(rsp_inhibit),
        .rsp_wthru(rsp_wthru), .rsp_viol(rsp_viol),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [31:0] ea;
        logic [3:0]  space;
        logic        wr;
        logic        hit;
        logic [31:0] pa;
        logic        inh;
        logic        wt;
        logic        viol;
    } vec_t;

    // ea, space, write, hit, pa, inhibit, wthru, violation
    localparam vec_t VECS [10] = '{
        '{32'h1234_5678, 4'd3, 1'b0, 1'b1, 32'hABCD_E678, 1'b1, 1'b0, 1'b0}, // R1 R5
        '{32'h1234_5678, 4'd3, 1'b1, 1'b1, 32'hABCD_E678, 1'b1, 1'b0, 1'b1}, // R4 read-only group
        '{32'h1234_5678, 4'd5, 1'b0, 1'b1, 32'h1111_1678, 1'b0, 1'b0, 1'b0}, // R3 other space
        '{32'h1234_5678, 4'd4, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0}, // R3 no space
        '{32'h4012_3456, 4'd3, 1'b1, 1'b1, 32'h8012_3456, 1'b0, 1'b1, 1'b0}, // R2 8MB
        '{32'h4080_0000, 4'd3, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0}, // R2 8MB edge
        '{32'h2000_6ABC, 4'd3, 1'b0, 1'b1, 32'h3000_AABC, 1'b0, 1'b0, 1'b0}, // R2 16KB
        '{32'h5002_1234, 4'd3, 1'b0, 1'b1, 32'h6006_1234, 1'b0, 1'b0, 1'b1}, // R2 256KB, R4 no rights
        '{32'h7007_FFF0, 4'd3, 1'b1, 1'b1, 32'h9007_FFF0, 1'b0, 1'b0, 1'b0}, // R2 512KB
        '{32'h7008_0000, 4'd3, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0}  // R2 512KB edge
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // tag word: epn, valid, space; data word: rpn, size, group, inhibit, wthru
    task automatic load_entry(input int idx, input logic [19:0] epn, input logic [3:0] sp,
                              input logic [19:0] rpn, input logic [2:0] sz,
                              input logic [2:0] grp, input logic inh, input logic wt);
        reg_write(4'd0, {epn, 1'b1, 7'd0, sp});
        reg_write(4'd1, {rpn, 1'b0, sz, 1'b0, grp, 2'b00, inh, wt});
        reg_write(4'd2, 32'(idx));
    endtask

    task automatic lookup(input logic [31:0] ea, input logic [3:0] sp, input logic w);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea; lk_space = sp; lk_write = w;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; lk_valid = 1'b0; lk_ea = '0; lk_space = '0; lk_write = 1'b0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        #1 check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", 32'(rsp_valid), 0);
        reg_read(4'd4, rd);
        check(rd == 32'hFFFF, "R11", "rights reset", rd, 32'hFFFF);
        reg_read(4'd6, rd);
        check(rd == 0, "R11", "scratch reset", rd, 0);
        lookup(32'h0000_0000, 4'd0, 1'b0);
        check(rsp_miss && !rsp_hit, "R11", "empty table miss", 32'(rsp_hit), 0);

        // table setup through the register port (R7)
        load_entry(0, 20'h12345, 4'd3, 20'hABCDE, 3'd0, 3'd1, 1'b1, 1'b0);
        load_entry(1, 20'h40000, 4'd3, 20'h80000, 3'd4, 3'd2, 1'b0, 1'b1);
        load_entry(2, 20'h12345, 4'd5, 20'h11111, 3'd0, 3'd0, 1'b0, 1'b0);
        load_entry(5, 20'h20004, 4'd3, 20'h30008, 3'd1, 3'd0, 1'b0, 1'b0);
        load_entry(7, 20'h50000, 4'd3, 20'h60040, 3'd2, 3'd3, 1'b0, 1'b0);
        load_entry(9, 20'h70000, 4'd3, 20'h90000, 3'd3, 3'd0, 1'b0, 1'b0);
        // group0 RW, group1 read only, group2 RW, group3 none (R4)
        reg_write(4'd4, 32'h0000_0037);
        reg_read(4'd0, rd);
        check(rd == {20'h70000, 1'b1, 7'd0, 4'd3}, "R7", "staging tag readback", rd,
              {20'h70000, 1'b1, 7'd0, 4'd3});

        for (int v = 0; v < 10; v++) begin
            lookup(VECS[v].ea, VECS[v].space, VECS[v].wr);
            check(rsp_valid, "R1", "rsp_valid", 32'(rsp_valid), 1);
            check(rsp_hit == VECS[v].hit && rsp_miss == !VECS[v].hit, "R1 R3 R6",
                  $sformatf("vec %0d hit", v), 32'(rsp_hit), 32'(VECS[v].hit));
            check(rsp_pa == VECS[v].pa, "R1 R2", $sformatf("vec %0d pa", v), rsp_pa, VECS[v].pa);
            check(rsp_inhibit == VECS[v].inh && rsp_wthru == VECS[v].wt, "R5",
                  $sformatf("vec %0d attrs", v), {rsp_inhibit, rsp_wthru},
                  {VECS[v].inh, VECS[v].wt});
            check(rsp_viol == VECS[v].viol, "R4", $sformatf("vec %0d viol", v),
                  32'(rsp_viol), 32'(VECS[v].viol));
            check(rsp_multi == 1'b0, "R9", $sformatf("vec %0d single", v), 32'(rsp_multi), 0);
        end

        // R6 miss pulse width and fault capture
        lookup(32'hDEAD_B000, 4'd3, 1'b0);
        check(rsp_miss, "R6", "miss pulse", 32'(rsp_miss), 1);
        @(negedge clk);
        check(!rsp_miss, "R6", "miss pulse ends", 32'(rsp_miss), 0);
        reg_read(4'd5, rd);
        check(rd == 32'hDEAD_B000, "R6", "fault address", rd, 32'hDEAD_B000);
        lookup(32'h1234_5000, 4'd3, 1'b0);
        reg_read(4'd5, rd);
        check(rd == 32'hDEAD_B000, "R6", "fault kept on hit", rd, 32'hDEAD_B000);

        // R10 fault register ignores writes, scratch read/write
        reg_write(4'd5, 32'h0BAD_0BAD);
        reg_read(4'd5, rd);
        check(rd == 32'hDEAD_B000, "R10", "fault write ignored", rd, 32'hDEAD_B000);
        reg_write(4'd6, 32'hA5A5_0001);
        reg_write(4'd7, 32'h5A5A_0002);
        reg_write(4'd8, 32'hC3C3_0003);
        reg_read(4'd6, rd);
        check(rd == 32'hA5A5_0001, "R10", "scratch0", rd, 32'hA5A5_0001);
        reg_read(4'd7, rd);
        check(rd == 32'h5A5A_0002, "R10", "scratch1", rd, 32'h5A5A_0002);
        reg_read(4'd8, rd);
        check(rd == 32'hC3C3_0003, "R10", "scratch2", rd, 32'hC3C3_0003);

        // R9 duplicate entry at slot 12: slot 0 wins
        load_entry(12, 20'h12345, 4'd3, 20'h22222, 3'd0, 3'd0, 1'b0, 1'b1);
        lookup(32'h1234_5678, 4'd3, 1'b0);
        check(rsp_multi && rsp_hit, "R9", "multi flag", 32'(rsp_multi), 1);
        check(rsp_pa == 32'hABCD_E678, "R9", "lowest index wins", rsp_pa, 32'hABCD_E678);

        // R7 overwrite slot 0: slot 12 now the only match
        load_entry(0, 20'h00001, 4'd3, 20'h00002, 3'd0, 3'd0, 1'b0, 1'b0);
        lookup(32'h1234_5678, 4'd3, 1'b0);
        check(rsp_pa == 32'h2222_2678 && !rsp_multi, "R7", "overwritten slot", rsp_pa,
              32'h2222_2678);
        lookup(32'h0000_1ABC, 4'd3, 1'b0);
        check(rsp_pa == 32'h0000_2ABC, "R7", "new slot 0 contents", rsp_pa, 32'h0000_2ABC);

        // R8 global invalidate
        reg_write(4'd3, 32'h0);
        lookup(32'h1234_5678, 4'd3, 1'b0);
        check(!rsp_hit && rsp_miss, "R8", "miss after invalidate", 32'(rsp_hit), 0);
        lookup(32'h4012_3456, 4'd3, 1'b0);
        check(!rsp_hit && rsp_pa == 0, "R8", "8MB gone", rsp_pa, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule